// File: doc/BRIEF.md
# Row-Phase Sequencer for a DRAM/SDRAM Memory Controller

This block runs the opening stretch of every external memory access that has to open a new page. It presents the row address and a cycle-type status code, and it drives the row strobe, the column strobes, write enable, the data buffer enable, the transfer-direction pin and the row-latch pin. All strobes are active-low and come from registers. A 3-bit timing code, sampled as the machine enters its second state, chooses the path: SDRAM (`0xx`), single-cycle column (`10x`), two-cycle column (`110`) or three-cycle column (`111`).

The sequencer samples fault, ready and retry from the memory system. It runs extra tail states for refresh cycles and a precharge-all drain state. It floats every pin while an external host owns the bus. When the row phase of a normal access ends, it hands over to a separate column sequencer with a one-cycle pulse. An abort input from the internal cycle arbiter restarts the access at the first row state.

Top module: `row_phase_seq`

## Requirements
- R1: After synchronous reset the state code is 0 (idle), every strobe output is high, `pin_oe` is 1 and `col_go` and `faulted` are 0. The state codes are: idle 0, S1..S6 = 1..6, spin 7, refresh tails T1/T2/T3 = 8/9/10, drain 11, bus-float 12.
- R2: `acc_start` sampled in idle moves the machine to S1 on the next clock. In S1, `addr_o` shows the requested row address, `stat_o` shows the requested cycle-type code, and all strobes are high.
- R3: The timing code and the access attributes are sampled on the clock that moves S1 to S2. From S2 until the row phase ends, `row_lat_n` is 0 and `dir_out` equals the write attribute.
- R4: In S3 `buf_en_n` is 0. In S3, fault low sends the machine to idle and pulses `faulted`, and retry low sends it back to S1. Fault wins over retry, and retry wins over ready.
- R5: S4 is visited only for timing code 111. Retry low in S4 returns the machine to S1.
- R6: S5 is visited for codes 0xx and 11x and is skipped for 10x. In S5, `ras_n` is 0. `we_n` is 0 for precharge-all or mode-set cycles (and for non-SDRAM writes). `cas_n` is 0 for mode-set cycles, for SDRAM refreshes and for non-SDRAM refreshes.
- R7: In S6, SDRAM cycles (code bit 2 = 0) drive `ras_n`, `cas_n` and `we_n` high. Other cycles drive `ras_n` = 0, `we_n` = not write and `cas_n` = not refresh.
- R8: Ready low held in S3 or S6 keeps the machine in that state for each such cycle.
- R9: After S6, a non-refresh access goes to spin for as long as `spin_req` is high. It then goes to idle, and `col_go` is 1 in the first idle cycle.
- R10: A refresh leaves S6 through T1 (codes 11x only), then T2 (code 111 only), then T3. In T1 to T3, `stat_o` shows `act_code`, and retry low returns the machine to S1.
- R11: The drain state follows T3 for SDRAM refreshes with `ras_n` = `we_n` = 0 and `cas_n` high. It follows S6 for pipelined writes with code 10x, with all strobes at 0. After a drained write, `col_go` pulses in idle.
- R12: `abort` sends the machine to S1 on the next clock from any state except idle and bus-float. Abort wins over fault, so `faulted` stays 0.
- R13: `host_req` in idle takes priority over `acc_start` and enters bus-float. The machine stays there, with `pin_oe` = 0, while `host_req` is high, and abort is ignored there. When `host_req` drops, it returns to idle with `pin_oe` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_start | input | 1 | Request for a new-page access |
| host_req | input | 1 | External host asks for the bus |
| abort | input | 1 | Arbiter abort in favour of a higher-priority cycle |
| row_addr | input | AW | Row address of the request |
| cyc_code | input | SW | Cycle-type status code of the request |
| act_code | input | SW | Activity code shown during refresh tails |
| is_write | input | 1 | Transfer direction (1 = write) |
| is_refresh | input | 1 | Refresh cycle |
| is_mrs | input | 1 | Mode-register-set cycle |
| is_pall | input | 1 | Precharge-all cycle |
| is_pipe | input | 1 | Pipelined single-cycle write |
| tcode | input | 3 | Cycle-timing code |
| fault_n | input | 1 | Fault, active low |
| ready_n | input | 1 | Not-ready, active low |
| retry_n | input | 1 | Retry, active low |
| spin_req | input | 1 | Column pipeline still loading |
| addr_o | output | AW | Row address out |
| stat_o | output | SW | Status code out |
| row_lat_n | output | 1 | Row latch strobe |
| dir_out | output | 1 | Data direction |
| buf_en_n | output | 1 | Data buffer enable |
| ras_n | output | 1 | Row strobe |
| cas_n | output | NCAS | Column strobes |
| we_n | output | 1 | Write enable |
| pin_oe | output | 1 | Output enable for all driven pins |
| col_go | output | 1 | Handoff pulse to the column sequencer |
| faulted | output | 1 | Access ended by a fault |
| state_o | output | 4 | Current state code |

## Verification
On every cycle, the embedded assertions check the following: S4 is only reached with a latched 111 code; ready-low holds S3; a fault lands in idle with the fault pulse; abort forces S1; S1 leaves every strobe inactive; S5 drives the row strobe; the bus-float state drops the output enable; and the handoff and fault pulses never coincide. Only the bench scenarios can show the complete state path for each timing code crossed with direction, refresh, mode-set, precharge-all and pipelining, along with the exact strobe levels in S5, S6 and drain. The same applies to the effect of held ready and spin, and to retry from S4 and from the refresh tails.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_R1 = 4'd1, S_R2 = 4'd2, S_R3 = 4'd3, S_R4 = 4'd4,
    S_R5 = 4'd5, S_R6 = 4'd6, S_SPIN = 4'd7, S_T1 = 4'd8, S_T2 = 4'd9,
    S_T3 = 4'd10, S_DRN = 4'd11, S_HIZ = 4'd12
  } rs_state_e;

  typedef struct packed {
    logic       wr;
    logic       rf;
    logic       mrs;
    logic       pall;
    logic       pw;
    logic [2:0] tc;
  } rs_attr_t;

  function automatic logic is_sdram(input logic [2:0] tc);
    return ~tc[2];
  endfunction
endpackage

// File: rtl/rs_attr_latch.sv
module rs_attr_latch
  import rowseq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_req,
  input  logic          load_attr,
  input  logic [AW-1:0] row_addr,
  input  rs_attr_t      attr_in,
  output logic [AW-1:0] addr_q,
  output rs_attr_t      attr_q,
  output rs_attr_t      attr_nxt
);
  assign attr_nxt = load_attr ? attr_in : attr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      attr_q <= '0;
    end else begin
      if (load_req)  addr_q <= row_addr;
      if (load_attr) attr_q <= attr_in;
    end
  end
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rowseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      acc_start,
  input  logic      host_req,
  input  logic      abort,
  input  logic      fault_n,
  input  logic      ready_n,
  input  logic      retry_n,
  input  logic      spin_req,
  input  rs_attr_t  attr_q,
  output rs_state_e st,
  output rs_state_e nxt,
  output logic      col_go,
  output logic      faulted
);
  logic use_r5, pipe_drain, col_go_d, fault_d;

  assign use_r5     = is_sdram(attr_q.tc) | (attr_q.tc[2:1] == 2'b11);
  assign pipe_drain = attr_q.pw & attr_q.wr & (attr_q.tc[2:1] == 2'b10);

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE: if (host_req) nxt = S_HIZ; else if (acc_start) nxt = S_R1;
      S_HIZ:  if (!host_req) nxt = S_IDLE;
      S_R1:   nxt = S_R2;
      S_R2:   nxt = S_R3;
      S_R3: begin
        if (!fault_n)                nxt = S_IDLE;
        else if (!retry_n)           nxt = S_R1;
        else if (!ready_n)           nxt = S_R3;
        else if (attr_q.tc == 3'b111) nxt = S_R4;
        else if (use_r5)             nxt = S_R5;
        else                         nxt = S_R6;
      end
      S_R4: nxt = !retry_n ? S_R1 : S_R5;
      S_R5: nxt = S_R6;
      S_R6, S_SPIN: begin
        if (!retry_n)                    nxt = S_R1;
        else if (st == S_R6 && !ready_n) nxt = S_R6;
        else if (attr_q.rf)              nxt = (attr_q.tc[2:1] == 2'b11) ? S_T1 : S_T3;
        else if (spin_req)               nxt = S_SPIN;
        else if (pipe_drain)             nxt = S_DRN;
        else                             nxt = S_IDLE;
      end
      S_T1: nxt = !retry_n ? S_R1 : ((attr_q.tc == 3'b111) ? S_T2 : S_T3);
      S_T2: nxt = !retry_n ? S_R1 : S_T3;
      S_T3: nxt = !retry_n ? S_R1 : (is_sdram(attr_q.tc) ? S_DRN : S_IDLE);
      S_DRN: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
    if (abort && st != S_IDLE && st != S_HIZ) nxt = S_R1;
  end

  assign col_go_d = !attr_q.rf && (nxt == S_IDLE) &&
                    (st == S_R6 || st == S_SPIN || st == S_DRN);
  assign fault_d  = (st == S_R3) && (nxt == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      col_go  <= 1'b0;
      faulted <= 1'b0;
    end else begin
      st      <= nxt;
      col_go  <= col_go_d;
      faulted <= fault_d;
    end
  end

  // R5: the extra column state is only reached with a latched 111 code
  a_r5_r4_code: assert property (@(posedge clk) disable iff (rst)
    st == S_R4 |-> attr_q.tc == 3'b111);
  // R8: ready low holds the third row state
  a_r8_ready_hold: assert property (@(posedge clk) disable iff (rst)
    (st == S_R3 && !ready_n && fault_n && retry_n && !abort) |=> st == S_R3);
  // R4: a fault ends in idle with the fault pulse
  a_r4_fault_idle: assert property (@(posedge clk) disable iff (rst)
    (st == S_R3 && !fault_n && !abort) |=> (faulted && st == S_IDLE));
  // R12: abort restarts at the first row state
  a_r12_abort: assert property (@(posedge clk) disable iff (rst)
    (abort && st != S_IDLE && st != S_HIZ) |=> st == S_R1);
  // R9: handoff and fault pulses are exclusive
  a_r9_pulse_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({col_go, faulted}));
endmodule

// File: rtl/rs_outdec.sv
module rs_outdec
  import rowseq_pkg::*;
#(
  parameter int SW   = 6,
  parameter int NCAS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  rs_state_e       st,
  input  rs_state_e       nxt,
  input  rs_attr_t        attr,
  input  logic [SW-1:0]   cyc_code,
  input  logic [SW-1:0]   act_code,
  output logic [SW-1:0]   stat_o,
  output logic            row_lat_n,
  output logic            dir_out,
  output logic            buf_en_n,
  output logic            ras_n,
  output logic [NCAS-1:0] cas_n,
  output logic            we_n,
  output logic            pin_oe
);
  logic ras_d, cas_d, we_d, ben_d, rl_d, dir_d, sd, hold_we, hold_cas, in_row, in_data;

  assign sd       = is_sdram(attr.tc);
  assign hold_we  = ~sd & attr.wr;
  assign hold_cas = ~sd & attr.rf;
  assign in_row   = (nxt >= S_R2) && (nxt <= S_DRN);
  assign in_data  = (nxt >= S_R3) && (nxt <= S_DRN);

  always_comb begin
    ras_d = 1'b1;
    cas_d = 1'b1;
    we_d  = 1'b1;
    rl_d  = ~in_row;
    dir_d = in_row & attr.wr;
    ben_d = ~in_data;
    unique case (nxt)
      S_R3, S_R4: begin
        we_d  = ~hold_we;
        cas_d = ~hold_cas;
      end
      S_R5: begin
        ras_d = 1'b0;
        we_d  = ~(hold_we | attr.pall | attr.mrs);
        cas_d = ~(hold_cas | attr.mrs | (sd & attr.rf));
      end
      S_R6, S_SPIN, S_T1, S_T2, S_T3: begin
        if (!sd) begin
          ras_d = 1'b0;
          we_d  = ~attr.wr;
          cas_d = ~attr.rf;
        end
      end
      S_DRN: begin
        ras_d = 1'b0;
        we_d  = 1'b0;
        cas_d = sd;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_o    <= '0;
      row_lat_n <= 1'b1;
      dir_out   <= 1'b0;
      buf_en_n  <= 1'b1;
      ras_n     <= 1'b1;
      we_n      <= 1'b1;
      pin_oe    <= 1'b1;
    end else begin
      if (nxt == S_T1 || nxt == S_T2 || nxt == S_T3) stat_o <= act_code;
      else if (nxt == S_R1)                          stat_o <= cyc_code;
      row_lat_n <= rl_d;
      dir_out   <= dir_d;
      buf_en_n  <= ben_d;
      ras_n     <= ras_d;
      we_n      <= we_d;
      pin_oe    <= (nxt != S_HIZ);
    end
  end

  for (genvar g = 0; g < NCAS; g++) begin : g_cas
    always_ff @(posedge clk) begin
      if (rst) cas_n[g] <= 1'b1;
      else     cas_n[g] <= cas_d;
    end
  end

  // R13: pins float while the host owns the bus
  a_r13_float: assert property (@(posedge clk) disable iff (rst)
    st == S_HIZ |-> !pin_oe);
  // R2: first row state keeps every strobe inactive
  a_r2_r1_quiet: assert property (@(posedge clk) disable iff (rst)
    st == S_R1 |-> (ras_n && we_n && (&cas_n) && buf_en_n));
  // R6: row strobe is driven in the fifth state
  a_r6_r5_ras: assert property (@(posedge clk) disable iff (rst)
    st == S_R5 |-> !ras_n);
endmodule

// File: rtl/row_phase_seq.sv
module row_phase_seq
  import rowseq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SW   = 6,
  parameter int NCAS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_start,
  input  logic            host_req,
  input  logic            abort,
  input  logic [AW-1:0]   row_addr,
  input  logic [SW-1:0]   cyc_code,
  input  logic [SW-1:0]   act_code,
  input  logic            is_write,
  input  logic            is_refresh,
  input  logic            is_mrs,
  input  logic            is_pall,
  input  logic            is_pipe,
  input  logic [2:0]      tcode,
  input  logic            fault_n,
  input  logic            ready_n,
  input  logic            retry_n,
  input  logic            spin_req,
  output logic [AW-1:0]   addr_o,
  output logic [SW-1:0]   stat_o,
  output logic            row_lat_n,
  output logic            dir_out,
  output logic            buf_en_n,
  output logic            ras_n,
  output logic [NCAS-1:0] cas_n,
  output logic            we_n,
  output logic            pin_oe,
  output logic            col_go,
  output logic            faulted,
  output logic [3:0]      state_o
);
  rs_state_e st, nxt;
  rs_attr_t  attr_in, attr_q, attr_nxt;

  assign attr_in = '{wr: is_write, rf: is_refresh, mrs: is_mrs,
                     pall: is_pall, pw: is_pipe, tc: tcode};
  assign state_o = st;

  rs_attr_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst(rst),
    .load_req(nxt == S_R1), .load_attr(st == S_R1),
    .row_addr(row_addr), .attr_in(attr_in),
    .addr_q(addr_o), .attr_q(attr_q), .attr_nxt(attr_nxt)
  );

  rs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .acc_start(acc_start), .host_req(host_req),
    .abort(abort), .fault_n(fault_n), .ready_n(ready_n), .retry_n(retry_n),
    .spin_req(spin_req), .attr_q(attr_q), .st(st), .nxt(nxt),
    .col_go(col_go), .faulted(faulted)
  );

  rs_outdec #(.SW(SW), .NCAS(NCAS)) u_out (
    .clk(clk), .rst(rst), .st(st), .nxt(nxt), .attr(attr_nxt),
    .cyc_code(cyc_code), .act_code(act_code), .stat_o(stat_o),
    .row_lat_n(row_lat_n), .dir_out(dir_out), .buf_en_n(buf_en_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .pin_oe(pin_oe)
  );
endmodule

// File: tb/sim_row_phase_seq.sv
module sim_row_phase_seq;
  localparam int AW = 16, SW = 6, NCAS = 2;
  localparam int IDLE = 0, R1 = 1, R2 = 2, R3 = 3, R4 = 4, R5 = 5, R6 = 6,
                 SPIN = 7, T1 = 8, T2 = 9, T3 = 10, DRN = 11, HIZ = 12;

  logic clk = 0, rst = 1;
  logic acc_start = 0, host_req = 0, abort = 0;
  logic [AW-1:0] row_addr = '0;
  logic [SW-1:0] cyc_code = '0, act_code = '0;
  logic is_write = 0, is_refresh = 0, is_mrs = 0, is_pall = 0, is_pipe = 0;
  logic [2:0] tcode = '0;
  logic fault_n = 1, ready_n = 1, retry_n = 1, spin_req = 0;
  logic [AW-1:0] addr_o;
  logic [SW-1:0] stat_o;
  logic row_lat_n, dir_out, buf_en_n, ras_n, we_n, pin_oe, col_go, faulted;
  logic [NCAS-1:0] cas_n;
  logic [3:0] state_o;

  int total = 0, fails = 0;

  always #4 clk = ~clk;

  row_phase_seq #(.AW(AW), .SW(SW), .NCAS(NCAS)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_until(input int s);
    for (int i = 0; i < 30 && state_o != s; i++) tick();
  endtask

  task automatic set_acc(input int tc, input bit w, input bit rf, input bit m,
                         input bit d, input bit p);
    tcode = tc[2:0]; is_write = w; is_refresh = rf; is_mrs = m;
    is_pall = d; is_pipe = p;
  endtask

  // expected strobe levels {ras,we,cas} from R6, R7, R11
  function automatic logic [2:0] exp_strb(input int s, input int tc, input bit w,
                                          input bit rf, input bit m, input bit d);
    bit sd = (tc < 4);
    logic [2:0] r = 3'b111;
    if (s == R5) r = {1'b0, !((!sd && w) || d || m), !((!sd && rf) || m || (sd && rf))};
    else if (s == R6) r = sd ? 3'b111 : {1'b0, !w, !rf};
    else if (s == DRN) r = {1'b0, 1'b0, sd};
    return r;
  endfunction

  task automatic run_access(input int tc, input bit w, input bit rf, input bit m,
                            input bit d, input bit p);
    int exp [16];
    int n = 0;
    logic [2:0] e;
    set_acc(tc, w, rf, m, d, p);
    row_addr = AW'(tc * 97 + w * 13 + rf * 5 + 1);
    cyc_code = SW'(tc + 8 * w);
    act_code = SW'(6'h2A);
    exp[n++] = R1; exp[n++] = R2; exp[n++] = R3;
    if (tc == 7) exp[n++] = R4;
    if (tc < 4 || tc >= 6) exp[n++] = R5;
    exp[n++] = R6;
    if (rf) begin
      if (tc >= 6) exp[n++] = T1;
      if (tc == 7) exp[n++] = T2;
      exp[n++] = T3;
      if (tc < 4) exp[n++] = DRN;
    end else if (p && w && (tc == 4 || tc == 5)) exp[n++] = DRN;
    exp[n++] = IDLE;
    acc_start = 1;
    tick();
    acc_start = 0;
    chk(addr_o == row_addr && stat_o == cyc_code, "R2 address/status in S1", int'(addr_o), int'(row_addr));
    for (int i = 0; i < n; i++) begin
      chk(state_o == exp[i], "R5/R6/R10/R11 state path", state_o, exp[i]);
      if (exp[i] == R2)
        chk(row_lat_n == 0 && dir_out == w, "R3 row latch/direction", {row_lat_n, dir_out}, {1'b0, w});
      if (exp[i] == R3) chk(buf_en_n == 0, "R4 buffer enable in S3", buf_en_n, 0);
      if (exp[i] == T3) chk(stat_o == act_code, "R10 activity code", stat_o, act_code);
      if (exp[i] == R5 || exp[i] == R6 || exp[i] == DRN) begin
        e = exp_strb(exp[i], tc, w, rf, m, d);
        chk({ras_n, we_n, cas_n[0]} == e && cas_n[NCAS-1] == e[0],
            exp[i] == R5 ? "R6 strobes in S5" : (exp[i] == R6 ? "R7 strobes in S6" : "R11 drain strobes"),
            {ras_n, we_n, cas_n[0]}, e);
      end
      if (exp[i] == IDLE) chk(col_go == !rf, "R9 handoff pulse", col_go, !rf);
      if (i < n - 1) tick();
    end
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); rst = 0;
    // R1 reset state
    chk(state_o == IDLE, "R1 reset state", state_o, IDLE);
    chk(ras_n && we_n && (&cas_n) && buf_en_n && row_lat_n && pin_oe && !col_go && !faulted,
        "R1 reset outputs", {ras_n, we_n, buf_en_n, pin_oe}, 4'b1111);

    // sweep over code x direction x refresh x special x pipelining
    for (int tc = 0; tc < 8; tc++)
      for (int w = 0; w < 2; w++)
        for (int rf = 0; rf < 2; rf++)
          for (int sp = 0; sp < 3; sp++)
            for (int p = 0; p < 2; p++)
              run_access(tc, w[0], rf[0], sp == 1, sp == 2, p[0]);

    // R8 ready hold in S3
    set_acc(6, 0, 0, 0, 0, 0); acc_start = 1; tick(); acc_start = 0;
    go_until(R3); ready_n = 0; tick();
    chk(state_o == R3, "R8 hold S3 cycle 1", state_o, R3); tick();
    chk(state_o == R3, "R8 hold S3 cycle 2", state_o, R3);
    ready_n = 1; tick();
    chk(state_o == R5, "R8 release to S5", state_o, R5);
    go_until(R6); ready_n = 0; tick();
    chk(state_o == R6, "R8 hold S6", state_o, R6);
    ready_n = 1; go_until(IDLE);

    // R9 spin
    set_acc(4, 0, 0, 0, 0, 0); acc_start = 1; tick(); acc_start = 0;
    go_until(R6); spin_req = 1; tick();
    chk(state_o == SPIN, "R9 spin entry", state_o, SPIN); tick();
    chk(state_o == SPIN, "R9 spin repeat", state_o, SPIN);
    spin_req = 0; tick();
    chk(state_o == IDLE && col_go, "R9 handoff after spin", {state_o, col_go}, {4'(IDLE), 1'b1});
    tick();

    // R4 fault wins over retry
    set_acc(2, 1, 0, 0, 0, 0); acc_start = 1; tick(); acc_start = 0;
    go_until(R3); fault_n = 0; retry_n = 0; tick();
    chk(state_o == IDLE && faulted, "R4 fault to idle", {state_o, faulted}, {4'(IDLE), 1'b1});
    fault_n = 1; retry_n = 1; tick();
    chk(!faulted, "R4 fault pulse one cycle", faulted, 0);

    // R4 retry in S3
    set_acc(2, 0, 0, 0, 0, 0); acc_start = 1; tick(); acc_start = 0;
    go_until(R3); retry_n = 0; ready_n = 0; tick();
    chk(state_o == R1, "R4 retry from S3", state_o, R1);
    retry_n = 1; ready_n = 1; go_until(IDLE);

    // R5 retry in S4
    set_acc(7, 0, 0, 0, 0, 0); acc_start = 1; tick(); acc_start = 0;
    go_until(R4); retry_n = 0; tick();
    chk(state_o == R1, "R5 retry from S4", state_o, R1);
    retry_n = 1; go_until(IDLE);

    // R10 retry in refresh tail
    set_acc(0, 0, 1, 0, 0, 0); acc_start = 1; tick(); acc_start = 0;
    go_until(T3); retry_n = 0; tick();
    chk(state_o == R1, "R10 retry from T3", state_o, R1);
    retry_n = 1; go_until(IDLE);

    // R12 abort beats fault
    set_acc(0, 0, 0, 0, 0, 0); acc_start = 1; tick(); acc_start = 0;
    go_until(R3); abort = 1; fault_n = 0; tick();
    chk(state_o == R1 && !faulted, "R12 abort over fault", {state_o, faulted}, {4'(R1), 1'b0});
    abort = 0; fault_n = 1; tick(); tick(); abort = 1; tick();
    chk(state_o == R1, "R12 abort from S3", state_o, R1);
    abort = 0; go_until(IDLE);

    // R13 bus float
    host_req = 1; acc_start = 1; tick(); acc_start = 0;
    chk(state_o == HIZ && !pin_oe, "R13 float entry", {state_o, pin_oe}, {4'(HIZ), 1'b0});
    abort = 1; tick();
    chk(state_o == HIZ && !pin_oe, "R13 float held, abort ignored", state_o, HIZ);
    abort = 0; host_req = 0; tick();
    chk(state_o == IDLE && pin_oe, "R13 release", {state_o, pin_oe}, {4'(IDLE), 1'b1});

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule